// File: doc/BRIEF.md
# Receive Character FIFO with Mode-Selected Flag Polarity

This block buffers received 14-bit characters. Each character is an 8-bit data value plus control tag bits. The receive control logic writes the characters and a host reads them back in arrival order. The buffer holds 256 entries. A write is accepted whenever space remains, and a write to a full buffer is dropped.

The host reads through a two-step select handshake. First, the host drives an address-select input high for one cycle. If the host then asserts the read enable in the very next cycle, the block performs a read. It raises a data output-enable and presents the oldest character on a registered output. The block drives three registered status flags: empty, full and half-full. Each flag also has an output-enable so that the flags can be modelled as tri-state pins. In any cycle where the address-select input was sampled low, the flags fall to their inactive levels.

A mode input selects between two interface timing models. When the mode is low, empty, full and the read enable are active-low. When the mode is high, the same three signals are active-high. The half-full flag is active-low in both modes. Everything runs on one clock with a synchronous active-high reset.

Top module: `rx_char_fifo`

## Requirements
- R1: Characters written to the buffer come out on `rd_char` in the same order. The buffer holds up to 256 characters of 14 bits.
- R2: A read happens, and `data_oe` is high after the clock edge, only when the read enable is sampled active at that edge and `addr_sel` was sampled high at the edge before it. Otherwise `data_oe` is low.
- R3: The occupancy never exceeds 256. A write while 256 characters are stored is dropped, so the stored characters are neither lost nor overwritten.
- R4: A granted read while the buffer is empty leaves `rd_char` unchanged and does not move the pointers. The empty flag stays active.
- R5: A granted read together with a write while the buffer is not empty leaves the occupancy unchanged.
- R6: With `cascade_mode` = 0, `empty_pin` and `full_pin` are 0 when active and 1 when inactive. `rd_en_pin` counts as active when it is 0.
- R7: With `cascade_mode` = 1, `empty_pin` and `full_pin` are 1 when active and 0 when inactive. `rd_en_pin` counts as active when it is 1.
- R8: `half_n_pin` is 0 exactly when the occupancy is 128 or more and the block is selected. This holds in both modes.
- R9: After an edge at which `addr_sel` is sampled low, `flag_oe` is 0 and all three flags sit at their inactive levels. After an edge at which `addr_sel` is sampled high, `flag_oe` is 1 and the flags show the occupancy that results from that same edge.
- R10: After reset the buffer is empty. `data_oe` and `flag_oe` are 0, `rd_char` is 0, and every flag sits at its inactive level for the present mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write side and the read side |
| rst | input | 1 | Synchronous reset, active high |
| cascade_mode | input | 1 | Polarity select: 0 gives active-low empty, full and read enable; 1 gives active-high |
| wr_valid | input | 1 | Write request from the receive control logic |
| wr_char | input | 14 | Character to store |
| addr_sel | input | 1 | Address-select strobe from the host, active high |
| rd_en_pin | input | 1 | Read enable; its polarity follows `cascade_mode` |
| rd_char | output | 14 | Registered read data |
| data_oe | output | 1 | Output-enable for `rd_char`; high in the cycle after a granted read |
| flag_oe | output | 1 | Output-enable for the status flags |
| empty_pin | output | 1 | Empty flag; its polarity follows `cascade_mode` |
| full_pin | output | 1 | Full flag; its polarity follows `cascade_mode` |
| half_n_pin | output | 1 | Half-full flag, always active low |

## Verification
The checker assumes that `cascade_mode` changes only while reset is held. The assertions and the output encodings rely on this. The bench therefore changes the mode only inside a reset pulse and runs one complete sweep per mode. The checker also assumes that the host follows every select cycle with at most one read enable. The bench does not depend on this: it drives reads with and without a preceding select, holds select high across back-to-back reads, and lets writes and reads coincide at empty, at half and at full. Every cycle, the bench checks all outputs against a queue model that it keeps itself.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

  // Convert an internal active-high condition to its pin level.
  function automatic logic to_pin(input logic active, input logic high_mode);
    return high_mode ? active : ~active;
  endfunction

  // Convert a pin level to an internal active-high condition.
  function automatic logic from_pin(input logic level, input logic high_mode);
    return high_mode ? level : ~level;
  endfunction

endpackage

// File: rtl/rxf_select.sv
`timescale 1ns/1ps
module rxf_select
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic high_mode,
  input  logic addr_sel,
  input  logic rd_en_pin,
  output logic sel_q,
  output logic grant
);

  // Remember the select strobe for one cycle; a read needs it first.
  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= addr_sel;
  end

  always_comb grant = sel_q && from_pin(rd_en_pin, high_mode);

endmodule

// File: rtl/rxf_ptrs.sv
`timescale 1ns/1ps
module rxf_ptrs #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_grant,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_next
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);
  localparam bit            POW2     = (DEPTH == (1 << AW));

  logic [AW-1:0] wr_inc, rd_inc;

  always_comb begin
    push = wr_req && (occ != FULL_CNT);
    pop  = rd_grant && (occ != '0);
  end

  // A power-of-two depth wraps for free; any other depth compares with the last index.
  generate
    if (POW2) begin : g_wrap_free
      always_comb begin
        wr_inc = wr_addr + 1'b1;
        rd_inc = rd_addr + 1'b1;
      end
    end else begin : g_wrap_cmp
      always_comb begin
        wr_inc = (wr_addr == LAST_IX) ? '0 : wr_addr + 1'b1;
        rd_inc = (rd_addr == LAST_IX) ? '0 : rd_addr + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    unique case ({push, pop})
      2'b10:   occ_next = occ + 1'b1;
      2'b01:   occ_next = occ - 1'b1;
      default: occ_next = occ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
      occ     <= '0;
    end else begin
      if (push) wr_addr <= wr_inc;
      if (pop)  rd_addr <= rd_inc;
      occ <= occ_next;
    end
  end

endmodule

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
  parameter int DW    = 14,
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port array, written in a form that infers block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The read register holds its value when no read happens.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxf_flags.sv
`timescale 1ns/1ps
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          high_mode,
  input  logic          addr_sel,
  input  logic [CW-1:0] occ_next,
  output logic          flag_oe,
  output logic          empty_pin,
  output logic          full_pin,
  output logic          half_n_pin
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_oe    <= 1'b0;
      empty_pin  <= to_pin(1'b0, high_mode);
      full_pin   <= to_pin(1'b0, high_mode);
      half_n_pin <= 1'b1;
    end else begin
      flag_oe    <= addr_sel;
      empty_pin  <= to_pin(addr_sel && (occ_next == '0), high_mode);
      full_pin   <= to_pin(addr_sel && (occ_next == FULL_CNT), high_mode);
      half_n_pin <= ~(addr_sel && (occ_next >= HALF_CNT));
    end
  end

endmodule

// File: rtl/rx_char_fifo.sv
`timescale 1ns/1ps
module rx_char_fifo #(
  parameter int DW    = 14,
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cascade_mode,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_char,
  input  logic          addr_sel,
  input  logic          rd_en_pin,
  output logic [DW-1:0] rd_char,
  output logic          data_oe,
  output logic          flag_oe,
  output logic          empty_pin,
  output logic          full_pin,
  output logic          half_n_pin
);

  logic          sel_q, grant, push, pop;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] occ, occ_next;

  rxf_select u_sel (
    .clk(clk), .rst(rst), .high_mode(cascade_mode),
    .addr_sel(addr_sel), .rd_en_pin(rd_en_pin),
    .sel_q(sel_q), .grant(grant)
  );

  rxf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .wr_req(wr_valid), .rd_grant(grant),
    .push(push), .pop(pop), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .occ(occ), .occ_next(occ_next)
  );

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(push), .waddr(wr_addr), .wdata(wr_char),
    .re(pop), .raddr(rd_addr), .rdata(rd_char)
  );

  rxf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .high_mode(cascade_mode), .addr_sel(addr_sel),
    .occ_next(occ_next), .flag_oe(flag_oe), .empty_pin(empty_pin),
    .full_pin(full_pin), .half_n_pin(half_n_pin)
  );

  // The data bus is enabled for every granted read, including one on an empty buffer.
  always_ff @(posedge clk) begin
    if (rst) data_oe <= 1'b0;
    else     data_oe <= grant;
  end

endmodule

// File: rtl/rx_char_fifo_chk.sv
`timescale 1ns/1ps
module rx_char_fifo_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          addr_sel,
  input logic          flag_oe,
  input logic          data_oe,
  input logic          half_n_pin,
  input logic [CW-1:0] occ,
  input logic          push,
  input logic          pop
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_CNT); // R3

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (occ == FULL_CNT && !pop) |=> (occ == FULL_CNT)); // R3

  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !pop); // R4

  AST_READ_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(addr_sel, 2)); // R2

  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(occ)); // R5

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(addr_sel) |-> (!flag_oe && half_n_pin)); // R9

endmodule

bind rx_char_fifo rx_char_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .addr_sel(addr_sel), .flag_oe(flag_oe),
  .data_oe(data_oe), .half_n_pin(half_n_pin), .occ(occ),
  .push(push), .pop(pop)
);

// File: tb/rx_char_fifo_test.sv
`timescale 1ns/1ps
module rx_char_fifo_test;

  localparam int DEPTH = 256;
  localparam int DW    = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_char = '0;
  logic          addr_sel = 1'b0;
  logic          rd_en_pin = 1'b1;
  logic [DW-1:0] rd_char;
  logic          data_oe, flag_oe, empty_pin, full_pin, half_n_pin;

  int checks = 0;
  int fails  = 0;

  // Bench-side model of the queue.
  logic [DW-1:0] q [DEPTH];
  int            head = 0, tail = 0, mcnt = 0;
  logic          prev_sel = 1'b0;
  logic [DW-1:0] exp_rd = '0;

  always #2 clk = ~clk;

  rx_char_fifo uut (
    .clk(clk), .rst(rst), .cascade_mode(mode), .wr_valid(wr_valid),
    .wr_char(wr_char), .addr_sel(addr_sel), .rd_en_pin(rd_en_pin),
    .rd_char(rd_char), .data_oe(data_oe), .flag_oe(flag_oe),
    .empty_pin(empty_pin), .full_pin(full_pin), .half_n_pin(half_n_pin)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic lvl(input logic active);
    return mode ? active : ~active;
  endfunction

  task automatic do_reset(input logic new_mode);
    rst = 1'b1; addr_sel = 1'b0; wr_valid = 1'b0;
    mode = new_mode; rd_en_pin = lvl(1'b0);
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    head = 0; tail = 0; mcnt = 0; prev_sel = 1'b0; exp_rd = '0;
    // R10: reset state
    chk(data_oe == 1'b0, "R10 data_oe", int'(data_oe), 0);
    chk(flag_oe == 1'b0, "R10 flag_oe", int'(flag_oe), 0);
    chk(rd_char == '0, "R10 rd_char", int'(rd_char), 0);
    chk(empty_pin == lvl(1'b0), "R10 empty_pin", int'(empty_pin), int'(lvl(1'b0)));
    chk(full_pin == lvl(1'b0), "R10 full_pin", int'(full_pin), int'(lvl(1'b0)));
    chk(half_n_pin == 1'b1, "R10 half_n_pin", int'(half_n_pin), 1);
  endtask

  // One clock cycle with the given stimulus, then check every output.
  task automatic cyc(input logic sel, input logic rd, input logic wr, input logic [DW-1:0] d);
    logic grant, pop, push;
    addr_sel = sel; rd_en_pin = lvl(rd); wr_valid = wr; wr_char = d;
    @(posedge clk);
    #1;
    grant = prev_sel && rd;
    pop   = grant && (mcnt > 0);
    push  = wr && (mcnt < DEPTH);
    if (pop) begin
      exp_rd = q[head];
      head = (head + 1) % DEPTH;
    end
    if (push) begin
      q[tail] = d;
      tail = (tail + 1) % DEPTH;
    end
    mcnt = mcnt + int'(push) - int'(pop);
    prev_sel = sel;
    chk(data_oe == grant, "R2 data_oe", int'(data_oe), int'(grant));
    chk(rd_char == exp_rd, "R1 rd_char", int'(rd_char), int'(exp_rd));
    chk(flag_oe == sel, "R9 flag_oe", int'(flag_oe), int'(sel));
    chk(half_n_pin == ~(sel && mcnt >= DEPTH / 2), "R8 half_n_pin",
        int'(half_n_pin), int'(~(sel && mcnt >= DEPTH / 2)));
    if (mode) begin
      chk(empty_pin == (sel && mcnt == 0), "R7 empty_pin", int'(empty_pin), int'(sel && mcnt == 0));
      chk(full_pin == (sel && mcnt == DEPTH), "R7 full_pin", int'(full_pin), int'(sel && mcnt == DEPTH));
    end else begin
      chk(empty_pin == ~(sel && mcnt == 0), "R6 empty_pin", int'(empty_pin), int'(~(sel && mcnt == 0)));
      chk(full_pin == ~(sel && mcnt == DEPTH), "R6 full_pin", int'(full_pin), int'(~(sel && mcnt == DEPTH)));
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i, input logic m);
    return DW'((i * 37 + 11 + (m ? 5003 : 0)) & ((1 << DW) - 1));
  endfunction

  task automatic sweep(input logic m);
    logic [DW-1:0] last_val;
    do_reset(m);
    // Read enable without a preceding select: no read (R2).
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    // Fill completely with select low, then probe the flags with select high.
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 1'b1, pat(i, m));
    last_val = pat(DEPTH - 1, m);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, pat(1000 + i, m));
    chk(full_pin == lvl(1'b1), "R3 full held", int'(full_pin), int'(lvl(1'b1)));
    // Drain with select held high: one read per cycle after the first select.
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b1, 1'b0, '0);
    chk(rd_char == last_val, "R3 last stored", int'(rd_char), int'(last_val));
    chk(empty_pin == lvl(1'b1), "R3 drained", int'(empty_pin), int'(lvl(1'b1)));
    // Reads on an empty buffer (R4).
    cyc(1'b1, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk(rd_char == last_val, "R4 rd_char hold", int'(rd_char), int'(last_val));
    chk(data_oe == 1'b1, "R4 data_oe", int'(data_oe), 1);
    // Write and read together on empty: the write lands, nothing is read.
    cyc(1'b1, 1'b1, 1'b1, pat(2000, m));
    // Fill to 10 entries, then simultaneous traffic (R5).
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 1'b1, pat(2001 + i, m));
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b1, pat(3000 + i, m));
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 1'b0, '0);
    chk(empty_pin == lvl(1'b0), "R5 not yet empty", int'(empty_pin), int'(lvl(1'b0)));
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk(empty_pin == lvl(1'b1), "R5 empty at 10", int'(empty_pin), int'(lvl(1'b1)));
    // Half-full boundary, stepping through 126..130 (R8).
    for (int i = 0; i < 130; i++) cyc(1'b1, 1'b0, 1'b1, pat(4000 + i, m));
    // Select pulses with reads one cycle later, and reads that lose their select.
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, 1'b0, '0);
      cyc(1'b0, 1'b1, 1'b0, '0);
      cyc(1'b0, 1'b1, 1'b0, '0);
    end
    chk(half_n_pin == 1'b1, "R9 unselected half", int'(half_n_pin), 1);
    for (int i = 0; i < 130; i++) cyc(1'b1, 1'b1, (i % 3) == 0, pat(5000 + i, m));
  endtask

  initial begin
    sweep(1'b0);
    sweep(1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule